// File: doc/BRIEF.md
# PWM Timebase Counter

This block is the time reference for a pulse-width modulator. A two-stage clock divider produces a count enable. On each enable a 16-bit counter moves through its period in one of four counting modes. The block emits single-clock pulses when the count lands on zero (TEZ) and when it lands on the period value (TEP). Surrounding logic compares against the count and uses these pulses to shape PWM edges.

The period is written into a shadow register. It reaches the active register at a moment chosen by configuration, so a running waveform can be retimed without a glitch. A run-control code starts the counter, stops it, or makes it run up to the next zero or period crossing and then halt with a stop pulse. A sync event reloads the count with a programmed phase value. The sync event is either a pulse on the sync input or any change of a software toggle bit. A selectable sync output lets further timers follow this one.

Top module: `pwm_timebase`

## Requirements
- R1: After reset the count is 0, the direction is 0, the counter is stopped, and tez, tep, stop_pulse and sync_out are all 0.
- R2: The count advances on one clock in every (clk_div+1)*(tmr_div+1) clocks. Both dividers are 8 bits wide.
- R3: With cnt_mode 1 (up), the count steps 0,1,..,P and then wraps to 0, where P is the active period. dir reads 0 (0 means incrementing).
- R4: With cnt_mode 2 (down), the count steps down to 0 and then reloads P. dir reads 1 (1 means decrementing).
- R5: With cnt_mode 3 (up-down), the count rises to P, then falls to 0, and repeats. dir is 0 from the step that leaves 0 up to and including P. dir is 1 from the step that leaves P down to and including 0.
- R6: With cnt_mode 0 (freeze), the count holds its value and no tez or tep pulse is produced.
- R7: tez is high for one clock in the same cycle that the count shows a newly reached 0. tep is high for one clock in the same cycle that the count shows a newly reached P.
- R8: The counter does not advance while stopped, and it is stopped after reset. A run write with code 2 starts free running. Code 3 starts a run that halts at the next zero. Code 4 starts a run that halts at the next period value.
- R9: A run write with code 0 (halt at next zero) or code 1 (halt at next period value) lets a running counter finish to that point and then hold. On the halting step, stop_pulse is high for one clock, in the same cycle as the matching tez or tep.
- R10: period_upd selects when the shadow period reaches the active period: 0 on every clock (immediately), 1 at a tez step, 2 at a sync event, 3 at tez or a sync event.
- R11: A sync event is a sync_in pulse or any change of sw_sync. When sync_en is 1, a sync event loads phase into the count on the next clock and takes priority over a coinciding count step. When sync_en is 0, the event leaves the count alone.
- R12: sync_out is registered. sync_out_sel 0 gives the sync event one clock later, 1 follows tez, 2 follows tep, and 3 gives constant 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_div | input | 8 | First divider stage value (divide by value+1) |
| tmr_div | input | 8 | Second divider stage value (divide by value+1) |
| period_wr | input | 1 | Write strobe for the period shadow register |
| period_data | input | 16 | Period value to write into the shadow |
| period_upd | input | 2 | Period update moment: 0 now, 1 zero, 2 sync, 3 zero or sync |
| run_wr | input | 1 | Write strobe for the run-control code |
| run_code | input | 3 | Run-control code, 0 to 4 |
| cnt_mode | input | 2 | Counting mode: 0 freeze, 1 up, 2 down, 3 up-down |
| sync_en | input | 1 | Allows a sync event to load phase into the count |
| sync_in | input | 1 | Hardware sync pulse |
| sw_sync | input | 1 | Software sync toggle; any change is one event |
| phase | input | 16 | Value loaded on sync |
| sync_out_sel | input | 2 | Sync output source select |
| count | output | 16 | Current count |
| dir | output | 1 | Direction, 0 incrementing, 1 decrementing |
| tez | output | 1 | Count reached zero pulse |
| tep | output | 1 | Count reached period pulse |
| stop_pulse | output | 1 | Counter halted by a run code |
| sync_out | output | 1 | Selected sync output |

## Verification
Two functions can act on the same clock: a sync reload and a counting step. With both dividers at 0 every clock is a counting step, so any sync_in pulse or sw_sync change while running lands on a step. The bench expects the next sample to show exactly the phase value with no tez, and the following sample to show phase+1. A second collision is a period shadow write or a sync-timed period update that coincides with a step. It is judged by the exact count sequence that follows the write, derived from the update rule.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;

   typedef enum logic [1:0] {
      CM_FREEZE = 2'd0,
      CM_UP     = 2'd1,
      CM_DOWN   = 2'd2,
      CM_UPDOWN = 2'd3
   } cnt_mode_e;

   typedef enum logic [1:0] {
      PU_NOW    = 2'd0,
      PU_ZERO   = 2'd1,
      PU_SYNC   = 2'd2,
      PU_EITHER = 2'd3
   } per_upd_e;

   typedef enum logic [1:0] {
      HALT_NONE = 2'd0,
      HALT_ZERO = 2'd1,
      HALT_TOP  = 2'd2
   } halt_e;

   typedef enum logic [1:0] {
      SO_SYNC = 2'd0,
      SO_ZERO = 2'd1,
      SO_TOP  = 2'd2,
      SO_OFF  = 2'd3
   } sync_sel_e;

   localparam logic [2:0] RC_HALT_ZERO = 3'd0;
   localparam logic [2:0] RC_HALT_TOP  = 3'd1;
   localparam logic [2:0] RC_FREE      = 3'd2;
   localparam logic [2:0] RC_ONCE_ZERO = 3'd3;
   localparam logic [2:0] RC_ONCE_TOP  = 3'd4;

endpackage

// File: rtl/pwmtb_prescaler.sv
module pwmtb_prescaler #(
   parameter int DW     = 8,
   parameter int STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [STAGES-1:0][DW-1:0]  div,
   output logic                       tick
);
   localparam logic [DW-1:0] STEP = 1;

   logic [STAGES:0] en;
   assign en[0] = 1'b1;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      logic [DW-1:0] cnt_q;
      logic          wrap;
      assign wrap      = (cnt_q >= div[g]);
      assign en[g+1]   = en[g] & wrap;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)     cnt_q <= '0;
         else if (en[g]) cnt_q <= wrap ? '0 : cnt_q + STEP;
      end
   end

   assign tick = en[STAGES];

   // R2: a non-zero first-stage divider never yields two enables in a row
   a_r2_stage_gap : assert property (@(posedge clk) disable iff (!rst_n)
      (en[1] && div[0] != '0) |=> (!en[1] || div[0] == '0));

endmodule

// File: rtl/pwmtb_period.sv
module pwmtb_period
   import pwmtb_pkg::*;
#(
   parameter int            CW   = 16,
   parameter logic [CW-1:0] INIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr,
   input  logic [CW-1:0] wr_data,
   input  per_upd_e      upd,
   input  logic          zero_evt,
   input  logic          sync_evt,
   output logic [CW-1:0] active
);
   logic [CW-1:0] shadow_q, active_q;
   logic          load;

   always_comb begin
      case (upd)
         PU_NOW:  load = 1'b1;
         PU_ZERO: load = zero_evt;
         PU_SYNC: load = sync_evt;
         default: load = zero_evt | sync_evt;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shadow_q <= INIT;
         active_q <= INIT;
      end else begin
         if (wr)   shadow_q <= wr_data;
         if (load) active_q <= shadow_q;
      end
   end

   assign active = active_q;

   // R10: in zero-timed mode the active period moves only on a zero step
   a_r10_zero_hold : assert property (@(posedge clk) disable iff (!rst_n)
      (upd == PU_ZERO && !zero_evt) |=> $stable(active_q));

endmodule

// File: rtl/pwmtb_runctl.sv
module pwmtb_runctl
   import pwmtb_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr,
   input  logic [2:0] code,
   input  logic       zero_evt,
   input  logic       top_evt,
   output logic       running,
   output logic       halted
);
   halt_e sel_q;
   logic  run_q, halt_q, hit;

   assign hit = run_q && ((sel_q == HALT_ZERO && zero_evt) ||
                          (sel_q == HALT_TOP  && top_evt));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q  <= 1'b0;
         sel_q  <= HALT_NONE;
         halt_q <= 1'b0;
      end else begin
         halt_q <= 1'b0;
         if (wr) begin
            case (code)
               RC_HALT_ZERO: sel_q <= HALT_ZERO;
               RC_HALT_TOP:  sel_q <= HALT_TOP;
               RC_FREE:      begin run_q <= 1'b1; sel_q <= HALT_NONE; end
               RC_ONCE_ZERO: begin run_q <= 1'b1; sel_q <= HALT_ZERO; end
               RC_ONCE_TOP:  begin run_q <= 1'b1; sel_q <= HALT_TOP;  end
               default: ;
            endcase
         end else if (hit) begin
            run_q  <= 1'b0;
            sel_q  <= HALT_NONE;
            halt_q <= 1'b1;
         end
      end
   end

   assign running = run_q;
   assign halted  = halt_q;

   // R9: a stop pulse leaves the counter stopped
   a_r9_halt_stops : assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> !run_q);
   // R9: a stop pulse is always caused by a zero or period step
   a_r9_halt_cause : assert property (@(posedge clk) disable iff (!rst_n)
      halt_q |-> $past(zero_evt || top_evt));
   // R8: start codes always leave the counter running
   a_r8_start_runs : assert property (@(posedge clk) disable iff (!rst_n)
      (wr && (code == RC_FREE || code == RC_ONCE_ZERO || code == RC_ONCE_TOP)) |=> run_q);

endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
   import pwmtb_pkg::*;
#(
   parameter int CW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic          running,
   input  cnt_mode_e     mode,
   input  logic [CW-1:0] per,
   input  logic          reload,
   input  logic [CW-1:0] phase,
   output logic [CW-1:0] count,
   output logic          dir,
   output logic          zero_evt,
   output logic          top_evt,
   output logic          zero_pulse,
   output logic          top_pulse
);
   localparam logic [CW-1:0] ONE = 1;

   logic [CW-1:0] cnt_q, nxt;
   logic          dir_q, dnx, adv, zero_q, top_q;

   assign adv = tick & running & (mode != CM_FREEZE);

   always_comb begin
      nxt = cnt_q;
      dnx = dir_q;
      case (mode)
         CM_UP: begin
            dnx = 1'b0;
            if (adv) nxt = (cnt_q >= per) ? '0 : cnt_q + ONE;
         end
         CM_DOWN: begin
            dnx = 1'b1;
            if (adv) nxt = (cnt_q == '0 || cnt_q > per) ? per : cnt_q - ONE;
         end
         CM_UPDOWN: begin
            if (adv) begin
               if (!dir_q) begin
                  if (cnt_q >= per) begin
                     dnx = 1'b1;
                     nxt = (cnt_q == '0) ? '0 : cnt_q - ONE;
                  end else begin
                     nxt = cnt_q + ONE;
                  end
               end else begin
                  if (cnt_q == '0) begin
                     dnx = 1'b0;
                     nxt = (per == '0) ? '0 : ONE;
                  end else begin
                     nxt = cnt_q - ONE;
                  end
               end
            end
         end
         default: ;
      endcase
      if (reload) begin
         nxt = phase;
         if (mode == CM_UPDOWN) dnx = dir_q;
      end
   end

   assign zero_evt = adv & ~reload & (nxt == '0);
   assign top_evt  = adv & ~reload & (nxt == per);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         dir_q  <= 1'b0;
         zero_q <= 1'b0;
         top_q  <= 1'b0;
      end else begin
         cnt_q  <= nxt;
         dir_q  <= dnx;
         zero_q <= zero_evt;
         top_q  <= top_evt;
      end
   end

   assign count      = cnt_q;
   assign dir        = dir_q;
   assign zero_pulse = zero_q;
   assign top_pulse  = top_q;

   // R7: zero pulse coincides with a count of zero
   a_r7_zero_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      zero_q |-> (cnt_q == '0));
   // R7: period pulse coincides with the count equal to the period used
   a_r7_top_pulse : assert property (@(posedge clk) disable iff (!rst_n)
      top_q |-> (cnt_q == $past(per)));
   // R6: freeze mode holds the count
   a_r6_freeze_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (mode == CM_FREEZE && !reload) |=> $stable(cnt_q));
   // R8: a stopped counter holds its count
   a_r8_idle_holds : assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !reload) |=> $stable(cnt_q));
   // R11: a sync reload shows the phase on the next clock
   a_r11_phase_load : assert property (@(posedge clk) disable iff (!rst_n)
      reload |=> (cnt_q == $past(phase)));

endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
   import pwmtb_pkg::*;
#(
   parameter int            CW       = 16,
   parameter int            PW       = 8,
   parameter logic [CW-1:0] PER_INIT = '1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [PW-1:0] clk_div,
   input  logic [PW-1:0] tmr_div,
   input  logic          period_wr,
   input  logic [CW-1:0] period_data,
   input  logic [1:0]    period_upd,
   input  logic          run_wr,
   input  logic [2:0]    run_code,
   input  logic [1:0]    cnt_mode,
   input  logic          sync_en,
   input  logic          sync_in,
   input  logic          sw_sync,
   input  logic [CW-1:0] phase,
   input  logic [1:0]    sync_out_sel,
   output logic [CW-1:0] count,
   output logic          dir,
   output logic          tez,
   output logic          tep,
   output logic          stop_pulse,
   output logic          sync_out
);
   localparam int DIV_STAGES = 2;

   if (CW < 2 || CW > 32) begin : g_bad_cw
      $error("pwm_timebase: CW must lie in 2..32");
   end
   if (PW < 1 || PW > 16) begin : g_bad_pw
      $error("pwm_timebase: PW must lie in 1..16");
   end

   logic          tick, running, zero_evt, top_evt;
   logic          sw_q, sync_evt, reload, so_q;
   logic [CW-1:0] per_active;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sw_q <= 1'b0;
      else        sw_q <= sw_sync;
   end

   assign sync_evt = sync_in | (sw_sync ^ sw_q);
   assign reload   = sync_evt & sync_en;

   pwmtb_prescaler #(.DW(PW), .STAGES(DIV_STAGES)) u_div (
      .clk   (clk),
      .rst_n (rst_n),
      .div   ({tmr_div, clk_div}),
      .tick  (tick)
   );

   pwmtb_period #(.CW(CW), .INIT(PER_INIT)) u_per (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (period_wr),
      .wr_data  (period_data),
      .upd      (per_upd_e'(period_upd)),
      .zero_evt (zero_evt),
      .sync_evt (sync_evt),
      .active   (per_active)
   );

   pwmtb_runctl u_run (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr       (run_wr),
      .code     (run_code),
      .zero_evt (zero_evt),
      .top_evt  (top_evt),
      .running  (running),
      .halted   (stop_pulse)
   );

   pwmtb_counter #(.CW(CW)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .tick       (tick),
      .running    (running),
      .mode       (cnt_mode_e'(cnt_mode)),
      .per        (per_active),
      .reload     (reload),
      .phase      (phase),
      .count      (count),
      .dir        (dir),
      .zero_evt   (zero_evt),
      .top_evt    (top_evt),
      .zero_pulse (tez),
      .top_pulse  (tep)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_q <= 1'b0;
      end else begin
         case (sync_sel_e'(sync_out_sel))
            SO_SYNC: so_q <= sync_evt;
            SO_ZERO: so_q <= zero_evt;
            SO_TOP:  so_q <= top_evt;
            default: so_q <= 1'b0;
         endcase
      end
   end

   assign sync_out = so_q;

   // R12: the disabled selection keeps the sync output low
   a_r12_off_quiet : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out_sel == 2'd3) |=> !sync_out);
   // R12: zero selection tracks the zero pulse
   a_r12_zero_follow : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_out_sel == 2'd1) |=> (sync_out == tez));

endmodule

// File: tb/test_pwm_timebase.sv
`timescale 1ns/1ps
module test_pwm_timebase;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [7:0]  clk_div, tmr_div;
   logic        period_wr;
   logic [15:0] period_data;
   logic [1:0]  period_upd;
   logic        run_wr;
   logic [2:0]  run_code;
   logic [1:0]  cnt_mode;
   logic        sync_en, sync_in, sw_sync;
   logic [15:0] phase;
   logic [1:0]  sync_out_sel;
   logic [15:0] count;
   logic        dir, tez, tep, stop_pulse, sync_out;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   pwm_timebase i_pwm_timebase (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .tmr_div(tmr_div),
      .period_wr(period_wr), .period_data(period_data), .period_upd(period_upd),
      .run_wr(run_wr), .run_code(run_code), .cnt_mode(cnt_mode),
      .sync_en(sync_en), .sync_in(sync_in), .sw_sync(sw_sync), .phase(phase),
      .sync_out_sel(sync_out_sel), .count(count), .dir(dir), .tez(tez),
      .tep(tep), .stop_pulse(stop_pulse), .sync_out(sync_out)
   );

   task automatic expect_eq(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      clk_div = '0; tmr_div = '0; period_wr = 0; period_data = '0;
      period_upd = 2'd0; run_wr = 0; run_code = '0; cnt_mode = 2'd0;
      sync_en = 0; sync_in = 0; sw_sync = 0; phase = '0; sync_out_sel = 2'd0;
      repeat (3) step();
      rst_n = 1'b1;
      step();
   endtask

   task automatic setup(input int mode, input int per);
      cnt_mode    = mode[1:0];
      period_upd  = 2'd0;
      period_data = per[15:0];
      period_wr   = 1'b1;
      step();
      period_wr   = 1'b0;
      step();
   endtask

   task automatic start(input int code);
      run_code = code[2:0];
      run_wr   = 1'b1;
      step();
      run_wr   = 1'b0;
   endtask

   task automatic period_case(input int m, input int e0, input int e1, input int e2,
                              input int e3, input int e4, input int e5, input int e6,
                              input int e7, input int e8);
      int exp_seq [9];
      exp_seq = '{e0, e1, e2, e3, e4, e5, e6, e7, e8};
      do_reset();
      setup(1, 5);
      start(2);
      period_upd = m[1:0];
      repeat (6) step();
      expect_eq("R10 count before write", int'(count), 0);
      period_data = 16'd2;
      period_wr   = 1'b1;
      for (int k = 0; k < 9; k++) begin
         step();
         period_wr = 1'b0;
         expect_eq($sformatf("R10 method %0d step %0d", m, k + 7), int'(count), exp_seq[k]);
         if (m == 2 && k == 2) sw_sync = 1'b1;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int c0;
      int seen;
      do_reset();
      // R1 reset state
      expect_eq("R1 count", int'(count), 0);
      expect_eq("R1 dir", int'(dir), 0);
      expect_eq("R1 tez", int'(tez), 0);
      expect_eq("R1 tep", int'(tep), 0);
      expect_eq("R1 stop_pulse", int'(stop_pulse), 0);
      expect_eq("R1 sync_out", int'(sync_out), 0);

      // R8 stopped after reset: no advance without a run code
      setup(1, 5);
      for (int k = 0; k < 6; k++) begin
         step();
         expect_eq("R8 idle count", int'(count), 0);
         expect_eq("R8 idle tez", int'(tez), 0);
      end

      // R3 R4 R5 R7 sweep over modes and periods
      for (int mode = 1; mode <= 3; mode++) begin
         for (int p = 1; p <= 6; p++) begin
            do_reset();
            setup(mode, p);
            start(2);
            for (int n = 1; n <= 2 * p + 2; n++) begin
               int ec, ed, m;
               step();
               if (mode == 1) begin
                  ec = n % (p + 1); ed = 0;
               end else if (mode == 2) begin
                  ec = (p + 1 - n % (p + 1)) % (p + 1); ed = 1;
               end else begin
                  m  = n % (2 * p);
                  ec = (m <= p) ? m : 2 * p - m;
                  ed = ((m > p) || (m == 0)) ? 1 : 0;
               end
               expect_eq($sformatf("R3/R4/R5 mode%0d P%0d n%0d count", mode, p, n), int'(count), ec);
               expect_eq($sformatf("R3/R4/R5 mode%0d P%0d n%0d dir", mode, p, n), int'(dir), ed);
               expect_eq($sformatf("R7 mode%0d P%0d n%0d tez", mode, p, n), int'(tez), (ec == 0) ? 1 : 0);
               expect_eq($sformatf("R7 mode%0d P%0d n%0d tep", mode, p, n), int'(tep), (ec == p) ? 1 : 0);
            end
         end
      end

      // R8 R9 code 3: run once to zero
      do_reset();
      setup(1, 4);
      start(3);
      for (int n = 1; n <= 10; n++) begin
         step();
         expect_eq($sformatf("R8 once-zero n%0d count", n), int'(count), (n < 5) ? n : 0);
         expect_eq($sformatf("R9 once-zero n%0d stop", n), int'(stop_pulse), (n == 5) ? 1 : 0);
      end
      // R8 R9 code 4: run once to period
      do_reset();
      setup(1, 4);
      start(4);
      for (int n = 1; n <= 10; n++) begin
         step();
         expect_eq($sformatf("R8 once-top n%0d count", n), int'(count), (n < 4) ? n : 4);
         expect_eq($sformatf("R9 once-top n%0d stop", n), int'(stop_pulse), (n == 4) ? 1 : 0);
      end
      // R9 code 0 while free running
      do_reset();
      setup(1, 4);
      start(2);
      repeat (2) step();
      run_code = 3'd0; run_wr = 1'b1;
      for (int n = 3; n <= 10; n++) begin
         step();
         run_wr = 1'b0;
         expect_eq($sformatf("R9 halt-zero n%0d count", n), int'(count), (n < 5) ? n : 0);
         expect_eq($sformatf("R9 halt-zero n%0d stop", n), int'(stop_pulse), (n == 5) ? 1 : 0);
      end
      // R9 code 1 while free running
      do_reset();
      setup(1, 4);
      start(2);
      step();
      run_code = 3'd1; run_wr = 1'b1;
      for (int n = 2; n <= 10; n++) begin
         step();
         run_wr = 1'b0;
         expect_eq($sformatf("R9 halt-top n%0d count", n), int'(count), (n < 4) ? n : 4);
         expect_eq($sformatf("R9 halt-top n%0d stop", n), int'(stop_pulse), (n == 4) ? 1 : 0);
      end

      // R6 freeze
      do_reset();
      setup(1, 20);
      start(2);
      repeat (3) step();
      cnt_mode = 2'd0;
      for (int k = 0; k < 8; k++) begin
         step();
         expect_eq("R6 freeze count", int'(count), 3);
         expect_eq("R6 freeze tez", int'(tez), 0);
      end

      // R2 prescaler
      do_reset();
      clk_div = 8'd2; tmr_div = 8'd1;
      setup(1, 1000);
      start(2);
      repeat (10) step();
      c0 = int'(count);
      repeat (60) step();
      expect_eq("R2 div 3x2 over 60 clocks", int'(count) - c0, 10);
      for (int k = 0; k < 5; k++) begin
         c0 = int'(count);
         repeat (6) step();
         expect_eq("R2 div 3x2 over 6 clocks", int'(count) - c0, 1);
      end
      clk_div = 8'd0; tmr_div = 8'd3;
      repeat (20) step();
      c0 = int'(count);
      repeat (40) step();
      expect_eq("R2 div 1x4 over 40 clocks", int'(count) - c0, 10);

      // R10 update methods
      period_case(0, 1, 2, 0, 1, 2, 0, 1, 2, 0);
      period_case(1, 1, 2, 3, 4, 5, 0, 1, 2, 0);
      period_case(2, 1, 2, 3, 4, 0, 1, 2, 0, 1);
      period_case(3, 1, 2, 3, 4, 5, 0, 1, 2, 0);

      // R11 R12 sync reload colliding with a count step
      do_reset();
      setup(1, 20);
      sync_en = 1'b1; phase = 16'd7; sync_out_sel = 2'd0;
      start(2);
      repeat (3) step();
      sync_in = 1'b1;
      step();
      sync_in = 1'b0;
      expect_eq("R11 sync_in loads phase", int'(count), 7);
      expect_eq("R11 no tez on reload", int'(tez), 0);
      expect_eq("R12 sel0 passes sync", int'(sync_out), 1);
      step();
      expect_eq("R11 count after reload", int'(count), 8);
      expect_eq("R12 sel0 pulse ends", int'(sync_out), 0);
      sw_sync = 1'b1;
      step();
      expect_eq("R11 sw toggle rise loads phase", int'(count), 7);
      expect_eq("R12 sel0 sw event", int'(sync_out), 1);
      step();
      expect_eq("R11 count after sw", int'(count), 8);
      sw_sync = 1'b0;
      step();
      expect_eq("R11 sw toggle fall loads phase", int'(count), 7);
      step();
      sync_en = 1'b0;
      sync_in = 1'b1;
      step();
      sync_in = 1'b0;
      expect_eq("R11 sync ignored when disabled", int'(count), 9);
      expect_eq("R12 sel0 event without reload", int'(sync_out), 1);
      sync_out_sel = 2'd3;
      sync_in = 1'b1;
      step();
      sync_in = 1'b0;
      expect_eq("R12 sel3 quiet", int'(sync_out), 0);
      expect_eq("R11 count still steps", int'(count), 10);
      sync_out_sel = 2'd1;
      step();
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         step();
         expect_eq("R12 sel1 follows tez", int'(sync_out), int'(tez));
         seen += int'(tez);
      end
      expect_eq("R12 sel1 tez seen", seen, 1);
      sync_out_sel = 2'd2;
      step();
      seen = 0;
      for (int k = 0; k < 30; k++) begin
         step();
         expect_eq("R12 sel2 follows tep", int'(sync_out), int'(tep));
         seen += int'(tep);
      end
      expect_eq("R12 sel2 tep seen", seen, 1);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule